// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches the enable and word address of each port. When both ports select the same word at once, it decides which port keeps going and signals "busy" (active low) toward the other one. It also suppresses that port's write strobe before it reaches the memory. The decision uses only the enables and addresses. Whether either access is a read or a write plays no part in it. Once made, the decision is held in a register until the collision ends.

A mode input picks one of two roles. In master mode the block arbitrates and drives the busy outputs. In slave mode it performs no arbitration. Each port's busy pin then acts as an external write-inhibit input, and the busy outputs stay high. Several such blocks can be placed side by side: one master makes the decision and the slaves follow it. Each cycle the block works out the winner from the current inputs, so inhibit and busy apply in the same cycle as the collision. The winner is stored for the following cycles.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: In master mode, a busy output goes low only when both enables (`ce_l_n`, `ce_r_n`, active low) are low and `addr_l` equals `addr_r`. In every other case both `busy_out_l_n` and `busy_out_r_n` are high.
- R2: A port counts as having arrived earlier when it already had its enable low at the same address at the previous rising clock edge. If only one port arrived earlier, it wins, and busy goes low on the other port in the first cycle of the collision.
- R3: If neither port arrived earlier (a tie), the left port wins and `busy_out_r_n` goes low. The two busy outputs are never low at the same time.
- R4: The winner does not depend on the write strobes `wr_l` and `wr_r`. The same arrival order gives the same busy outputs for reads and for writes.
- R5: `mem_we_x` equals `wr_x` AND NOT inhibit, where inhibit in master mode is that port's own busy output being low. The level on `busy_in_x_n` has no effect in master mode.
- R6: In slave mode (`master_mode` = 0), both busy outputs are high. A low `busy_in_x_n` blocks the writes of port x, a high level lets them pass, and address matches have no effect.
- R7: As long as the collision continues in master mode, the winner stays the same, even when both ports have since become stable.
- R8: Busy is released in the cycle in which the addresses differ or either enable goes high. A later collision is arbitrated afresh.
- R9: A synchronous active-high reset clears the stored winner and the arrival history. After reset with idle inputs, both busy outputs are high. A collision present right after reset counts as a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = busy pins are write-inhibit inputs |
| ce_l_n | input | 1 | Left port enable, active low |
| addr_l | input | ADDR_W | Left port word address |
| wr_l | input | 1 | Left port write strobe, active high |
| busy_in_l_n | input | 1 | Left external write-inhibit, active low (slave mode) |
| ce_r_n | input | 1 | Right port enable, active low |
| addr_r | input | ADDR_W | Right port word address |
| wr_r | input | 1 | Right port write strobe, active high |
| busy_in_r_n | input | 1 | Right external write-inhibit, active low (slave mode) |
| busy_out_l_n | output | 1 | Busy toward left port, active low |
| busy_out_r_n | output | 1 | Busy toward right port, active low |
| mem_we_l | output | 1 | Gated left write enable to the memory |
| mem_we_r | output | 1 | Gated right write enable to the memory |

## Verification
The properties assume that inputs change only between clock edges and stay stable around each rising edge. This is the only way the "arrived earlier" history reflects real arrival order. The hold property also assumes that any reset lasts at least one cycle before the collision being checked.

The stimulus drives every input on the falling edge and samples the outputs just before the next rising edge. It switches `master_mode` only while no stored winner matters, so the hold property is never tested across a mode change.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   localparam int NPORTS = 2;
   localparam int P_LEFT = 0;
   localparam int P_RIGHT = 1;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_LEFT  = 2'd1,
      WIN_RIGHT = 2'd2
   } win_e;

endpackage

// File: rtl/dpa_arrival.sv
// Remembers where a port stood at the previous edge, so that "arrived
// earlier" can be told apart from "arrived now".
module dpa_arrival #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              settled
);

   logic              prev_ce_n;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_ce_n <= 1'b1;
         prev_addr <= '0;
      end else begin
         prev_ce_n <= ce_n;
         prev_addr <= addr;
      end
   end

   assign settled = !prev_ce_n && !ce_n && (prev_addr == addr);

endmodule

// File: rtl/dpa_match.sv
// Collision comparator: both enables low and identical word address.
module dpa_match #(
   parameter int ADDR_W = 12
) (
   input  logic              ce_l_n,
   input  logic              ce_r_n,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   output logic              collide
);

   logic addr_eq;

   assign addr_eq = (addr_l == addr_r);
   assign collide = !ce_l_n && !ce_r_n && addr_eq;

endmodule

// File: rtl/dpa_winner.sv
// Chooses and holds the winner of a collision.
module dpa_winner
   import dpa_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic arb_en,
   input  logic collide,
   input  logic settled_l,
   input  logic settled_r,
   output logic lose_l,
   output logic lose_r
);

   win_e held_q;
   win_e fresh;
   win_e win_now;

   // Only a port that was already in place while the other was not takes
   // the right to proceed; every other case is a tie, resolved to the left.
   always_comb begin
      if (settled_r && !settled_l) fresh = WIN_RIGHT;
      else                         fresh = WIN_LEFT;
   end

   always_comb begin
      if (!arb_en || !collide)     win_now = WIN_NONE;
      else if (held_q != WIN_NONE) win_now = held_q;
      else                         win_now = fresh;
   end

   always_ff @(posedge clk) begin
      if (rst) held_q <= WIN_NONE;
      else     held_q <= win_now;
   end

   assign lose_l = (win_now == WIN_RIGHT);
   assign lose_r = (win_now == WIN_LEFT);

   // R7: a continuing collision keeps the earlier loser busy
   p_hold_right_lost_r7: assert property (@(posedge clk) disable iff (rst)
      (arb_en && collide && $past(arb_en && collide && !rst) && $past(lose_r))
      |-> lose_r);

   p_hold_left_lost_r7: assert property (@(posedge clk) disable iff (rst)
      (arb_en && collide && $past(arb_en && collide && !rst) && $past(lose_l))
      |-> lose_l);

   // R9: the winner store is empty in the cycle after a reset
   p_reset_clears_r9: assert property (@(posedge clk)
      rst |=> (held_q == WIN_NONE));

endmodule

// File: rtl/dpa_gate.sv
// Per-port mode select and write gating.
module dpa_gate (
   input  logic master,
   input  logic lose,
   input  logic busy_in_n,
   input  logic wr_req,
   output logic busy_out_n,
   output logic mem_we
);

   logic inhibit;

   always_comb begin
      if (master) begin
         inhibit    = lose;
         busy_out_n = !lose;
      end else begin
         inhibit    = !busy_in_n;
         busy_out_n = 1'b1;
      end
   end

   assign mem_we = wr_req && !inhibit;

endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              master_mode,
   input  logic              ce_l_n,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic              wr_l,
   input  logic              busy_in_l_n,
   input  logic              ce_r_n,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic              wr_r,
   input  logic              busy_in_r_n,
   output logic              busy_out_l_n,
   output logic              busy_out_r_n,
   output logic              mem_we_l,
   output logic              mem_we_r
);

   localparam int MAX_ADDR_W = 32;

   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
      $error("dpa_collision_arbiter: ADDR_W out of range");
   end

   logic [NPORTS-1:0]             ce_n_v;
   logic [NPORTS-1:0][ADDR_W-1:0] addr_v;
   logic [NPORTS-1:0]             wr_v;
   logic [NPORTS-1:0]             bin_v;
   logic [NPORTS-1:0]             settled_v;
   logic [NPORTS-1:0]             lose_v;
   logic [NPORTS-1:0]             bout_v;
   logic [NPORTS-1:0]             we_v;
   logic                          collide;

   assign ce_n_v[P_LEFT]  = ce_l_n;
   assign ce_n_v[P_RIGHT] = ce_r_n;
   assign addr_v[P_LEFT]  = addr_l;
   assign addr_v[P_RIGHT] = addr_r;
   assign wr_v[P_LEFT]    = wr_l;
   assign wr_v[P_RIGHT]   = wr_r;
   assign bin_v[P_LEFT]   = busy_in_l_n;
   assign bin_v[P_RIGHT]  = busy_in_r_n;

   dpa_match #(.ADDR_W(ADDR_W)) u_match (
      .ce_l_n  (ce_l_n),
      .ce_r_n  (ce_r_n),
      .addr_l  (addr_l),
      .addr_r  (addr_r),
      .collide (collide)
   );

   dpa_winner u_winner (
      .clk       (clk),
      .rst       (rst),
      .arb_en    (master_mode),
      .collide   (collide),
      .settled_l (settled_v[P_LEFT]),
      .settled_r (settled_v[P_RIGHT]),
      .lose_l    (lose_v[P_LEFT]),
      .lose_r    (lose_v[P_RIGHT])
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      dpa_arrival #(.ADDR_W(ADDR_W)) u_arrival (
         .clk     (clk),
         .rst     (rst),
         .ce_n    (ce_n_v[p]),
         .addr    (addr_v[p]),
         .settled (settled_v[p])
      );

      dpa_gate u_gate (
         .master     (master_mode),
         .lose       (lose_v[p]),
         .busy_in_n  (bin_v[p]),
         .wr_req     (wr_v[p]),
         .busy_out_n (bout_v[p]),
         .mem_we     (we_v[p])
      );
   end

   assign busy_out_l_n = bout_v[P_LEFT];
   assign busy_out_r_n = bout_v[P_RIGHT];
   assign mem_we_l     = we_v[P_LEFT];
   assign mem_we_r     = we_v[P_RIGHT];

   // R1: busy only on a real match of enabled addresses in master mode
   p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (rst)
      (!busy_out_l_n || !busy_out_r_n)
      |-> (master_mode && !ce_l_n && !ce_r_n && (addr_l == addr_r)));

   // R3: never both sides busy
   p_one_busy_only_r3: assert property (@(posedge clk) disable iff (rst)
      !(!busy_out_l_n && !busy_out_r_n));

   // R5: a busy port in master mode never writes
   p_block_left_r5: assert property (@(posedge clk) disable iff (rst)
      (master_mode && !busy_out_l_n) |-> !mem_we_l);

   p_block_right_r5: assert property (@(posedge clk) disable iff (rst)
      (master_mode && !busy_out_r_n) |-> !mem_we_r);

   // R6: slave mode keeps busy high and follows the inhibit pins
   p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !master_mode |-> (busy_out_l_n && busy_out_r_n));

   p_slave_gate_r6: assert property (@(posedge clk) disable iff (rst)
      (!master_mode && (!busy_in_l_n || !busy_in_r_n))
      |-> !((!busy_in_l_n && mem_we_l) || (!busy_in_r_n && mem_we_r)));

endmodule

// File: tb/tb_dpa_collision_arbiter.sv
module tb_dpa_collision_arbiter;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 12;
   localparam int NVEC   = 16;

   typedef struct packed {
      logic              master;
      logic              ce_l_n;
      logic              ce_r_n;
      logic [ADDR_W-1:0] a_l;
      logic [ADDR_W-1:0] a_r;
      logic              wr_l;
      logic              wr_r;
      logic              bi_l_n;
      logic              bi_r_n;
      logic              eb_l;
      logic              eb_r;
      logic              ew_l;
      logic              ew_r;
      logic [3:0]        req;
   } vec_t;

   // master, ce_l_n, ce_r_n, a_l, a_r, wr_l, wr_r, bi_l_n, bi_r_n,
   // expected busy_l_n, busy_r_n, mem_we_l, mem_we_r, requirement
   localparam vec_t VECS [NVEC] = '{
      '{1'b1,1'b1,1'b1,12'h005,12'h005,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1 both off
      '{1'b1,1'b0,1'b1,12'h005,12'h005,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1 one on
      '{1'b1,1'b0,1'b0,12'h005,12'h006,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1 differ
      '{1'b1,1'b0,1'b0,12'h005,12'h005,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd2}, // R2 left first
      '{1'b1,1'b0,1'b0,12'h005,12'h005,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd7}, // R7 hold
      '{1'b1,1'b0,1'b1,12'h005,12'h005,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd8}, // R8 ce off
      '{1'b1,1'b0,1'b0,12'h007,12'h007,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd3}, // R3 tie
      '{1'b1,1'b1,1'b0,12'h007,12'h007,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd8}, // R8 release
      '{1'b1,1'b0,1'b0,12'h007,12'h007,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd5}, // R5 right first
      '{1'b1,1'b0,1'b0,12'h007,12'h007,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 4'd7}, // R7 hold
      '{1'b1,1'b0,1'b0,12'h008,12'h007,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd8}, // R8 addr moves
      '{1'b1,1'b0,1'b0,12'h007,12'h007,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4 reads
      '{1'b0,1'b0,1'b0,12'h007,12'h007,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1, 4'd6}, // R6 left held
      '{1'b0,1'b0,1'b0,12'h007,12'h007,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd6}, // R6 right held
      '{1'b0,1'b1,1'b1,12'h007,12'h007,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd6}, // R6 free
      '{1'b1,1'b0,1'b0,12'hFFF,12'hFFF,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd5}  // R5 pin ignored
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              master_mode = 1'b1;
   logic              ce_l_n = 1'b1;
   logic [ADDR_W-1:0] addr_l = '0;
   logic              wr_l = 1'b0;
   logic              busy_in_l_n = 1'b1;
   logic              ce_r_n = 1'b1;
   logic [ADDR_W-1:0] addr_r = '0;
   logic              wr_r = 1'b0;
   logic              busy_in_r_n = 1'b1;
   logic              busy_out_l_n;
   logic              busy_out_r_n;
   logic              mem_we_l;
   logic              mem_we_r;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #(CLK_P/2) clk = !clk;

   dpa_collision_arbiter #(.ADDR_W(ADDR_W)) dut (
      .clk          (clk),
      .rst          (rst),
      .master_mode  (master_mode),
      .ce_l_n       (ce_l_n),
      .addr_l       (addr_l),
      .wr_l         (wr_l),
      .busy_in_l_n  (busy_in_l_n),
      .ce_r_n       (ce_r_n),
      .addr_r       (addr_r),
      .wr_r         (wr_r),
      .busy_in_r_n  (busy_in_r_n),
      .busy_out_l_n (busy_out_l_n),
      .busy_out_r_n (busy_out_r_n),
      .mem_we_l     (mem_we_l),
      .mem_we_r     (mem_we_r)
   );

   task automatic check(input string tag, input string what,
                        input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t",
                  tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag, input logic eb_l,
                            input logic eb_r, input logic ew_l,
                            input logic ew_r);
      check(tag, "busy_out_l_n", busy_out_l_n, eb_l);
      check(tag, "busy_out_r_n", busy_out_r_n, eb_r);
      check(tag, "mem_we_l", mem_we_l, ew_l);
      check(tag, "mem_we_r", mem_we_r, ew_r);
   endtask

   task automatic drive(input logic m, input logic cl, input logic cr,
                        input logic [ADDR_W-1:0] al,
                        input logic [ADDR_W-1:0] ar,
                        input logic wl, input logic wrr,
                        input logic bl, input logic br);
      master_mode = m;
      ce_l_n = cl;      ce_r_n = cr;
      addr_l = al;      addr_r = ar;
      wr_l = wl;        wr_r = wrr;
      busy_in_l_n = bl; busy_in_r_n = br;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors",
                  n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_all("R9 after reset", 1'b1, 1'b1, 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i].master, VECS[i].ce_l_n, VECS[i].ce_r_n,
               VECS[i].a_l, VECS[i].a_r, VECS[i].wr_l, VECS[i].wr_r,
               VECS[i].bi_l_n, VECS[i].bi_r_n);
         #1;
         check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                   VECS[i].eb_l, VECS[i].eb_r, VECS[i].ew_l, VECS[i].ew_r);
      end

      // R8 then R2: idle, right alone, then left joins late -> right wins
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 12'h003, 12'h003, 1'b0, 1'b0, 1'b1, 1'b1);
      #1;
      check_all("R8 idle", 1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b0, 12'h003, 12'h003, 1'b0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 12'h003, 12'h003, 1'b1, 1'b0, 1'b1, 1'b1);
      #1;
      check_all("R2 right first", 1'b0, 1'b1, 1'b0, 1'b0);

      // R9: reset in mid-collision wipes the history, giving a left-wins tie
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_all("R9 reset tie", 1'b1, 1'b0, 1'b1, 1'b0);

      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1);
      #1;
      check_all("R1 final idle", 1'b1, 1'b1, 1'b0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors",
               n_checks, n_errors);
      $finish;
   end

endmodule